// File: doc/BRIEF.md
# Control Transfer Data-Phase Sequencer

This block sits beside the control endpoint of a device-side USB function. It takes in the eight bytes of a SETUP packet as a byte stream. From them it decodes the direction, request type, recipient, request code and data-phase length. It then follows the data phase packet by packet. Each packet is at most eight bytes, and the endpoint confirms every packet with a one-cycle acknowledge.

For device-to-host transfers, the byte total is the smaller of the requested length and the reply size. The reply size is given as an input. The sequencer shows the size of the next packet and whether that packet ends the transfer. A packet shorter than eight bytes ends the transfer. Reaching the requested length also ends it. When the reply runs out on a full eight-byte packet before the requested length is reached, the sequencer adds a zero-length packet. A SET_ADDRESS request stores the new device address. The address only takes effect when the status stage is reported complete.

A new SETUP token abandons whatever transfer is in progress and restarts the parse.

Top module: `ctl_xfer_seq`

## Requirements
- R1: After reset, `state_o` is IDLE (2'd0), `pkt_len_o` is 0, `last_pkt_o` and `xfer_done_o` are low, and `dev_addr_o` is 0.
- R2: Setup byte 0 is decoded into three fields. Bit 7 gives the direction: 1 means IN (`state_o`=2'd1) and 0 means OUT (`state_o`=2'd2). Bits 6:5 drive `req_type_o` (0 standard, 1 class, 2 vendor) and bits 4:0 drive `recipient_o`. Byte 1 drives `req_code_o`. All outputs are valid from the cycle after the eighth byte is accepted.
- R3: Bytes 6 (low) and 7 (high) form the 16-bit data-phase length. A length of zero leaves `state_o` at IDLE and produces no `xfer_done_o` pulse.
- R4: The byte total is defined by direction. For IN, it is min(length, `reply_avail_i` sampled with byte 7). For OUT, it is the length. `pkt_len_o` equals min(8, total minus bytes already acknowledged).
- R5: `last_pkt_o` is high in a data state when `pkt_len_o` < 8 or when the acknowledged bytes plus `pkt_len_o` equal the length. An acknowledge of that packet returns `state_o` to IDLE. `xfer_done_o` is then high for exactly the next cycle.
- R6: Consider an IN transfer whose reply ends on a full eight-byte packet, while fewer bytes than the length have been sent. The next packet then has `pkt_len_o`=0 and `last_pkt_o`=1. The same applies when the reply is empty from the start.
- R7: A standard request (type 0) with request code 5 latches byte 2 bits 6:0 as a pending address. `dev_addr_o` takes that value one cycle after `status_done_i` is seen while `state_o` is IDLE. `status_done_i` during the data phase is ignored, and so is a code 5 request of another type.
- R8: `setup_start_i` returns `state_o` to IDLE on the next cycle. It clears the byte counters and drops any pending address, and the following eight setup bytes are parsed afresh.
- R9: `pkt_ack_i` while `state_o` is IDLE has no effect on `state_o`, `pkt_len_o` or `xfer_done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| setup_start_i | input | 1 | SETUP token seen, restart parse |
| setup_valid_i | input | 1 | Setup byte valid |
| setup_byte_i | input | 8 | Setup byte, byte 0 first |
| reply_avail_i | input | 16 | Reply bytes available for an IN data phase |
| pkt_ack_i | input | 1 | Current data packet moved |
| status_done_i | input | 1 | Status stage complete |
| state_o | output | 2 | 0 IDLE, 1 IN, 2 OUT |
| pkt_len_o | output | 4 | Size of next data packet |
| last_pkt_o | output | 1 | Next packet ends the transfer |
| xfer_done_o | output | 1 | One-cycle data-phase completion pulse |
| req_type_o | output | 2 | Request type field |
| recipient_o | output | 5 | Recipient field |
| req_code_o | output | 8 | Request code |
| dev_addr_o | output | 7 | Applied device address |

## Verification
The bench targets several corner cases, each paired here with the failure it would expose:
- A reply ending on an eight-byte boundary short of the requested length. Omitting the zero-length packet would stop the sequence early.
- A reply ending exactly at the requested length. An extra zero-length packet would hold the state in IN for one acknowledge too many.
- An empty reply and a zero-length request. These expose a design that emits an eight-byte or negative-count packet.
- A restart in the middle of a transfer. A stale sent count would shrink the next packet.
- A SET_ADDRESS that arrives with a data phase, or that is followed by a restart. Either would show an address applied too early or applied after it was abandoned.
- Acknowledges while idle. A design that counted these would produce a spurious completion pulse.

// File: rtl/ctl_seq_pkg.sv
package ctl_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_IN   = 2'd1,
    ST_OUT  = 2'd2
  } xfer_state_e;

  localparam int unsigned SETUP_BYTES   = 8;
  localparam logic [1:0]  RT_STANDARD   = 2'd0;
  localparam logic [7:0]  CODE_SET_ADDR = 8'd5;
endpackage

// File: rtl/setup_parser.sv
module setup_parser
  import ctl_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [7:0]        byte_i,
  output logic              done_o,
  output logic [7:0]        b0_o,
  output logic [7:0]        code_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [15:0]       len_o
);
  localparam int unsigned IDX_W = $clog2(SETUP_BYTES + 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(SETUP_BYTES - 1);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(SETUP_BYTES);

  logic [IDX_W-1:0]  idx_q;
  logic [7:0]        b0_q, code_q, len_lo_q;
  logic [ADDR_W-1:0] addr_q;
  logic              take;

  assign take   = valid_i && !start_i && (idx_q != IDX_FULL);
  assign done_o = take && (idx_q == IDX_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      b0_q     <= '0;
      code_q   <= '0;
      addr_q   <= '0;
      len_lo_q <= '0;
    end else if (start_i) begin
      idx_q <= '0;
    end else if (take) begin
      idx_q <= idx_q + 1'b1;
      case (idx_q)
        IDX_W'(0): b0_q     <= byte_i;
        IDX_W'(1): code_q   <= byte_i;
        IDX_W'(2): addr_q   <= byte_i[ADDR_W-1:0];
        IDX_W'(6): len_lo_q <= byte_i;
        default: ;
      endcase
    end
  end

  assign b0_o   = b0_q;
  assign code_o = code_q;
  assign addr_o = addr_q;
  assign len_o  = {byte_i, len_lo_q};

  AST_ONE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3
endmodule

// File: rtl/phase_tracker.sv
module phase_tracker
  import ctl_seq_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned PKT_MAX = 8,
  localparam int unsigned PL_W   = $clog2(PKT_MAX + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             load_i,
  input  logic             dir_in_i,
  input  logic [LEN_W-1:0] wlen_i,
  input  logic [LEN_W-1:0] avail_i,
  input  logic             ack_i,
  output xfer_state_e      state_o,
  output logic [PL_W-1:0]  pkt_len_o,
  output logic             last_o,
  output logic             done_o
);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(PKT_MAX);
  localparam logic [PL_W-1:0]  MAX_P = PL_W'(PKT_MAX);

  xfer_state_e      state_q;
  logic [LEN_W-1:0] total_q, wlen_q, sent_q, rem, total_d;
  logic [PL_W-1:0]  len_c;
  logic             last_c, done_q, busy;

  assign busy    = (state_q != ST_IDLE);
  assign total_d = (dir_in_i && (avail_i < wlen_i)) ? avail_i : wlen_i;
  assign rem     = total_q - sent_q;

  always_comb begin
    len_c  = '0;
    last_c = 1'b0;
    if (busy) begin
      len_c  = (rem > MAX_L) ? MAX_P : rem[PL_W-1:0];
      // short packet or requested length reached; covers zero-length tail
      last_c = (len_c < MAX_P) || ((sent_q + LEN_W'(len_c)) == wlen_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      total_q <= '0;
      wlen_q  <= '0;
      sent_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_IDLE;
        sent_q  <= '0;
      end else if (load_i) begin
        total_q <= total_d;
        wlen_q  <= wlen_i;
        sent_q  <= '0;
        if (wlen_i == '0)   state_q <= ST_IDLE;
        else if (dir_in_i)  state_q <= ST_IN;
        else                state_q <= ST_OUT;
      end else if (ack_i && busy) begin
        sent_q <= sent_q + LEN_W'(len_c);
        if (last_c) begin
          state_q <= ST_IDLE;
          done_q  <= 1'b1;
        end
      end
    end
  end

  assign state_o   = state_q;
  assign pkt_len_o = len_c;
  assign last_o    = last_c;
  assign done_o    = done_q;

  AST_PKT_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_len_o <= MAX_P); // R4
  AST_SENT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (sent_q <= total_q)); // R4
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (state_q == ST_IDLE)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> (pkt_len_o == '0 && !last_o)); // R9
  AST_START_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_q == ST_IDLE)); // R8
endmodule

// File: rtl/addr_ctl.sv
module addr_ctl #(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              load_i,
  input  logic              set_addr_i,
  input  logic [ADDR_W-1:0] new_addr_i,
  input  logic              idle_i,
  input  logic              status_done_i,
  output logic [ADDR_W-1:0] dev_addr_o
);
  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q, dev_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      dev_addr_q  <= '0;
    end else if (start_i) begin
      pend_q <= 1'b0;
    end else if (load_i) begin
      pend_q      <= set_addr_i;
      pend_addr_q <= new_addr_i;
    end else if (status_done_i && idle_i && pend_q) begin
      dev_addr_q <= pend_addr_q;
      pend_q     <= 1'b0;
    end
  end

  assign dev_addr_o = dev_addr_q;

  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_done_i |=> $stable(dev_addr_q)); // R7
endmodule

// File: rtl/ctl_xfer_seq.sv
module ctl_xfer_seq
  import ctl_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned PKT_MAX = 8,
  localparam int unsigned PL_W   = $clog2(PKT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              setup_start_i,
  input  logic              setup_valid_i,
  input  logic [7:0]        setup_byte_i,
  input  logic [15:0]       reply_avail_i,
  input  logic              pkt_ack_i,
  input  logic              status_done_i,
  output logic [1:0]        state_o,
  output logic [PL_W-1:0]   pkt_len_o,
  output logic              last_pkt_o,
  output logic              xfer_done_o,
  output logic [1:0]        req_type_o,
  output logic [4:0]        recipient_o,
  output logic [7:0]        req_code_o,
  output logic [ADDR_W-1:0] dev_addr_o
);
  logic              parsed, is_set_addr;
  logic [7:0]        b0, code;
  logic [ADDR_W-1:0] addr;
  logic [15:0]       wlen;
  xfer_state_e       state;
  logic [1:0]        rtype_q;
  logic [4:0]        recip_q;
  logic [7:0]        code_q;

  setup_parser #(.ADDR_W(ADDR_W)) u_parser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (setup_start_i),
    .valid_i (setup_valid_i),
    .byte_i  (setup_byte_i),
    .done_o  (parsed),
    .b0_o    (b0),
    .code_o  (code),
    .addr_o  (addr),
    .len_o   (wlen)
  );

  phase_tracker #(.LEN_W(16), .PKT_MAX(PKT_MAX)) u_tracker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (setup_start_i),
    .load_i    (parsed),
    .dir_in_i  (b0[7]),
    .wlen_i    (wlen),
    .avail_i   (reply_avail_i),
    .ack_i     (pkt_ack_i),
    .state_o   (state),
    .pkt_len_o (pkt_len_o),
    .last_o    (last_pkt_o),
    .done_o    (xfer_done_o)
  );

  assign is_set_addr = (b0[6:5] == RT_STANDARD) && (code == CODE_SET_ADDR);

  addr_ctl #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (setup_start_i),
    .load_i        (parsed),
    .set_addr_i    (is_set_addr),
    .new_addr_i    (addr),
    .idle_i        (state == ST_IDLE),
    .status_done_i (status_done_i),
    .dev_addr_o    (dev_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rtype_q <= '0;
      recip_q <= '0;
      code_q  <= '0;
    end else if (parsed) begin
      rtype_q <= b0[6:5];
      recip_q <= b0[4:0];
      code_q  <= code;
    end
  end

  assign state_o     = state;
  assign req_type_o  = rtype_q;
  assign recipient_o = recip_q;
  assign req_code_o  = code_q;

  AST_LOAD_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parsed |=> (req_code_o == $past(code))); // R2
endmodule

// File: tb/test_ctl_xfer_seq.sv
module test_ctl_xfer_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        setup_start_i = 1'b0, setup_valid_i = 1'b0;
  logic [7:0]  setup_byte_i = '0;
  logic [15:0] reply_avail_i = '0;
  logic        pkt_ack_i = 1'b0, status_done_i = 1'b0;
  logic [1:0]  state_o;
  logic [3:0]  pkt_len_o;
  logic        last_pkt_o, xfer_done_o;
  logic [1:0]  req_type_o;
  logic [4:0]  recipient_o;
  logic [7:0]  req_code_o;
  logic [6:0]  dev_addr_o;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk_i = ~clk_i;

  ctl_xfer_seq i_ctl_xfer_seq (.*);

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  function automatic int exp_len(int total, int sent);
    int rem = total - sent;
    return (rem > 8) ? 8 : rem;
  endfunction

  function automatic int exp_last(int total, int wlen, int sent);
    int l = exp_len(total, sent);
    return ((l < 8) || (sent + l == wlen)) ? 1 : 0;
  endfunction

  task automatic send_setup(logic [7:0] b0, logic [7:0] code, logic [7:0] b2,
                            logic [15:0] wlen, logic [15:0] avail);
    logic [7:0] pkt [8];
    pkt = '{b0, code, b2, 8'h00, 8'h00, 8'h00, wlen[7:0], wlen[15:8]};
    reply_avail_i = avail;
    setup_start_i = 1'b1;
    cyc();
    setup_start_i = 1'b0;
    for (int i = 0; i < 8; i++) begin
      setup_valid_i = 1'b1;
      setup_byte_i  = pkt[i];
      cyc();
    end
    setup_valid_i = 1'b0;
  endtask

  // walk a full data phase, checking every packet against the model
  task automatic run_phase(logic dir_in, int wlen, int avail);
    int total = (dir_in && avail < wlen) ? avail : wlen;
    int sent = 0;
    int st = (wlen == 0) ? 0 : (dir_in ? 1 : 2);
    check("R2 state after setup", state_o, st);
    if (wlen == 0) begin
      cyc();
      check("R3 zero length no done", xfer_done_o, 0);
      return;
    end
    for (int k = 0; k < 9000; k++) begin
      int l = exp_len(total, sent);
      int e = exp_last(total, wlen, sent);
      check("R4 packet length", pkt_len_o, l);
      check("R5 last flag", last_pkt_o, e);
      pkt_ack_i = 1'b1;
      cyc();
      pkt_ack_i = 1'b0;
      check("R5 done pulse", xfer_done_o, e);
      sent += l;
      if (e) begin
        check("R5 idle after last", state_o, 0);
        cyc();
        check("R5 done one cycle", xfer_done_o, 0);
        return;
      end
      check("R5 state held", state_o, st);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    report();
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) cyc();
    check("R1 state", state_o, 0);
    check("R1 pkt_len", pkt_len_o, 0);
    check("R1 last", last_pkt_o, 0);
    check("R1 done", xfer_done_o, 0);
    check("R1 addr", dev_addr_o, 0);
    rst_ni = 1'b1;
    cyc();

    // R2 field decode
    send_setup(8'b1_10_00011, 8'h2A, 8'h00, 16'd4, 16'd4);
    check("R2 req_type", req_type_o, 2);
    check("R2 recipient", recipient_o, 3);
    check("R2 req_code", req_code_o, 8'h2A);
    run_phase(1'b1, 4, 4);

    // R6 zlp: reply 16 of 20
    send_setup(8'h80, 8'h06, 8'h00, 16'd20, 16'd16);
    run_phase(1'b1, 20, 16);
    // exact boundary, no zlp
    send_setup(8'h80, 8'h06, 8'h00, 16'd16, 16'd16);
    run_phase(1'b1, 16, 16);
    // empty reply: single zero-length packet R6
    send_setup(8'h80, 8'h06, 8'h00, 16'd5, 16'd0);
    check("R6 empty reply len", pkt_len_o, 0);
    check("R6 empty reply last", last_pkt_o, 1);
    run_phase(1'b1, 5, 0);
    // R3 zero length, length bytes little-endian
    send_setup(8'h00, 8'h09, 8'h00, 16'd0, 16'd0);
    run_phase(1'b0, 0, 0);
    send_setup(8'h00, 8'h09, 8'h00, 16'h0102, 16'd0);
    run_phase(1'b0, 16'h0102, 0);
    // OUT ignores avail
    send_setup(8'h40, 8'h01, 8'h00, 16'd13, 16'd2);
    run_phase(1'b0, 13, 2);

    // R9 ack in idle
    pkt_ack_i = 1'b1;
    cyc();
    pkt_ack_i = 1'b0;
    check("R9 idle ack state", state_o, 0);
    check("R9 idle ack done", xfer_done_o, 0);
    check("R9 idle ack len", pkt_len_o, 0);

    // R8 restart mid transfer
    send_setup(8'h80, 8'h06, 8'h00, 16'd40, 16'd40);
    pkt_ack_i = 1'b1;
    cyc();
    pkt_ack_i = 1'b0;
    setup_start_i = 1'b1;
    cyc();
    setup_start_i = 1'b0;
    check("R8 restart idle", state_o, 0);
    send_setup(8'h00, 8'h03, 8'h00, 16'd3, 16'd0);
    check("R8 fresh parse state", state_o, 2);
    check("R8 sent cleared", pkt_len_o, 3);
    run_phase(1'b0, 3, 0);

    // R7 set address
    send_setup(8'h00, 8'h05, 8'h2B, 16'd0, 16'd0);
    check("R7 not yet applied", dev_addr_o, 0);
    status_done_i = 1'b1;
    cyc();
    status_done_i = 1'b0;
    check("R7 applied", dev_addr_o, 8'h2B);
    // class type code 5 ignored
    send_setup(8'h20, 8'h05, 8'h11, 16'd0, 16'd0);
    status_done_i = 1'b1;
    cyc();
    status_done_i = 1'b0;
    check("R7 class code5 ignored", dev_addr_o, 8'h2B);
    // status during data phase ignored, then applied
    send_setup(8'h00, 8'h05, 8'h33, 16'd2, 16'd0);
    status_done_i = 1'b1;
    cyc();
    status_done_i = 1'b0;
    check("R7 status in data phase", dev_addr_o, 8'h2B);
    run_phase(1'b0, 2, 0);
    status_done_i = 1'b1;
    cyc();
    status_done_i = 1'b0;
    check("R7 applied after phase", dev_addr_o, 8'h33);
    // R8 restart drops pending address
    send_setup(8'h00, 8'h05, 8'h44, 16'd0, 16'd0);
    send_setup(8'h80, 8'h00, 8'h00, 16'd0, 16'd0);
    status_done_i = 1'b1;
    cyc();
    status_done_i = 1'b0;
    check("R8 pending dropped", dev_addr_o, 8'h33);

    // random transfers
    for (int t = 0; t < 60; t++) begin
      logic        d = 1'($urandom_range(0, 1));
      int          w = $urandom_range(0, 70);
      int          a = $urandom_range(0, 80);
      logic [1:0]  ty = 2'($urandom_range(0, 2));
      logic [4:0]  rc = 5'($urandom_range(0, 31));
      logic [7:0]  cd = 8'($urandom_range(6, 255));
      if (t % 7 == 0) a = (w / 8) * 8;
      send_setup({d, ty, rc}, cd, 8'h00, 16'(w), 16'(a));
      check("R2 rand type", req_type_o, ty);
      check("R2 rand recip", recipient_o, rc);
      check("R2 rand code", req_code_o, cd);
      run_phase(d, w, a);
    end
    report();
  end
endmodule